// File: doc/BRIEF.md
# DRAM and CPU Clock Sequencer

This block turns a fast master clock into the timing backbone of a small home-computer memory system. It divides the master clock into repeating 8-cycle slots. Each slot opens one DRAM row on a bank of four 64K×1 devices and uses the two column strobes to move one byte as two nybbles. It also generates the 2 MHz CPU clock and keeps it locked to that strobe pattern. A slot is given to one of three owners: a display fetch, a CPU access, or a RAS-only refresh of the next row from an internal counter.

In the bandwidth-heavy display modes the display owns every slot of an active scanline. A CPU that asks for DRAM during that time is held with its clock low until the display stops fetching. In the lighter modes the display takes only the even slots, so a CPU request that lands on an even slot is stretched by one slot. A gap counter forces a refresh slot ahead of the CPU when too many slots have passed without one. Read bytes go back to the CPU on a data bus, and fetched display bytes are handed to the pixel logic with a one-cycle valid pulse.

Top module: `dram_clk_seq`

## Requirements
- R1: After reset, slots of 8 master cycles repeat, numbered phase 0 to 7 from the first cycle after reset. `ras_n` is high in phases 0 and 1 and low in phases 2 to 7.
- R2: In a slot that does not stall the CPU, `phi0` is low in phases 0 to 3 and high in phases 4 to 7, giving a 50% duty cycle at one eighth of the master rate.
- R3: For a display or CPU slot with byte address A (`AW` bits), `dram_addr` shows A[AW-1:MW-1] in phase 1, {A[MW-2:0],0} in phases 2 and 3, and {A[MW-2:0],1} in phases 4 to 7 and in phase 0 of the next slot. Here MW=(AW+1)/2. The address is set up at least one master cycle before each strobe falls.
- R4: `cas_n` is low exactly in phases 3 and 5 of display and CPU slots and never low in refresh slots.
- R5: Slot ownership is decided from the inputs in phase 0, in this priority: display fetch, then forced refresh, then CPU (`cpu_ram`=1), then idle refresh.
- R6: A slot whose phase-0 `cpu_ram` is 1 but which is not given to the CPU keeps `phi0` low for all 8 cycles. With `disp_active`=1 and `hi_bw`=1, every slot is a display slot, so the CPU stays stalled until `disp_active` falls.
- R7: With `disp_active`=1 and `hi_bw`=0, only slots with an even index (counting from 0 after reset) are display slots.
- R8: A refresh slot shows the refresh row on `dram_addr` from phase 1 through phase 0 of the next slot. The row then advances by one, wrapping at 2^MW. After REF_GAP-1 consecutive non-refresh slots, the next slot that is not a display slot is a forced refresh.
- R9: In a CPU slot with `cpu_rw`=0, `we_n` is low in phases 2 to 5. `dram_d` carries `cpu_wdata[3:0]` in phases 2 and 3 and `cpu_wdata[7:4]` in phases 4 and 5. All of these come from the phase-0 inputs.
- R10: In a CPU read slot, `cpu_rdata` takes {nybble sampled in phase 5, nybble sampled in phase 3} from phase 6 on, and holds it until the next CPU read.
- R11: In a display slot, `vid_data` takes the byte assembled in the same way, and `vid_valid` is high in phase 6 only.
- R12: During reset, `ras_n`, `cas_n` and `we_n` are high, `phi0` and `vid_valid` are low, and `dram_addr` and `cpu_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cpu_addr | input | AW | CPU byte address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_ram | input | 1 | CPU cycle targets DRAM |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | byte read for the CPU |
| phi0 | output | 1 | CPU clock |
| vid_addr | input | AW | display fetch byte address |
| disp_active | input | 1 | active scanline in progress |
| hi_bw | input | 1 | bandwidth-heavy display mode |
| vid_data | output | 8 | fetched display byte |
| vid_valid | output | 1 | one-cycle pulse when vid_data is new |
| dram_addr | output | MW | multiplexed row/column address |
| ras_n | output | 1 | row strobe, active low |
| cas_n | output | 1 | column strobe, active low |
| we_n | output | 1 | write enable, active low |
| dram_d | output | 4 | write nybble to DRAM |
| dram_q | input | 4 | read nybble from DRAM |

## Verification
The functions most likely to collide are the refresh deadline and a CPU request. Both can fall on the same phase-0 decision, and a display need can land there as well. A long stream of back-to-back CPU reads drives the gap counter to its limit. Randomly changing display and request inputs then make all three arrive together. The bench's own slot-by-slot model judges each case from `phi0` (stall or not), `cas_n` (whether strobes are present) and the row shown in phase 1, which must match the expected refresh counter value or the expected source address.

// File: rtl/dram_clk_seq.sv
`timescale 1ns/1ps
module dram_clk_seq #(
  parameter int AW      = 15,
  parameter int REF_GAP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw,
  input  logic          cpu_ram,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          phi0,
  input  logic [AW-1:0] vid_addr,
  input  logic          disp_active,
  input  logic          hi_bw,
  output logic [7:0]    vid_data,
  output logic          vid_valid,
  output logic [(AW+1)/2-1:0] dram_addr,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [3:0]    dram_d,
  input  logic [3:0]    dram_q
);
  localparam int MW = (AW + 1) / 2;
  localparam int GW = $clog2(REF_GAP);

  typedef enum logic [1:0] {K_REF, K_VID, K_CPU} kind_t;

  logic [2:0]    ph;
  kind_t         kind, pick;
  logic          stall, wr, par;
  logic [MW-1:0] ref_row, ca, cb;
  logic [GW-1:0] gap;
  logic [7:0]    wd;
  logic [3:0]    lo;
  logic [AW-1:0] src;

  wire vid_need  = disp_active & (hi_bw | ~par);
  wire force_ref = (gap == GW'(REF_GAP - 1));

  always_comb begin
    if (vid_need)      pick = K_VID;
    else if (force_ref) pick = K_REF;
    else if (cpu_ram)  pick = K_CPU;
    else               pick = K_REF;
  end

  assign src = (pick == K_VID) ? vid_addr : cpu_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= '0;
      kind      <= K_REF;
      stall     <= 1'b0;
      wr        <= 1'b0;
      par       <= 1'b0;
      ref_row   <= '0;
      ca        <= '0;
      cb        <= '0;
      gap       <= '0;
      wd        <= '0;
      lo        <= '0;
      dram_addr <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      dram_d    <= '0;
      phi0      <= 1'b0;
      cpu_rdata <= '0;
      vid_data  <= '0;
      vid_valid <= 1'b0;
    end else begin
      ph <= ph + 3'd1;
      case (ph)
        3'd0: begin
          kind  <= pick;
          stall <= cpu_ram && (pick != K_CPU);
          wr    <= (pick == K_CPU) && !cpu_rw;
          wd    <= cpu_wdata;
          if (pick == K_REF) begin
            dram_addr <= ref_row;
            ca        <= ref_row;
            cb        <= ref_row;
            ref_row   <= ref_row + MW'(1);
            gap       <= '0;
          end else begin
            dram_addr <= src[AW-1:MW-1];
            ca        <= {src[MW-2:0], 1'b0};
            cb        <= {src[MW-2:0], 1'b1};
            if (!force_ref) gap <= gap + GW'(1);
          end
        end
        3'd1: begin
          ras_n     <= 1'b0;
          dram_addr <= ca;
          if (wr) begin
            we_n   <= 1'b0;
            dram_d <= wd[3:0];
          end
        end
        3'd2: cas_n <= (kind == K_REF);
        3'd3: begin
          cas_n     <= 1'b1;
          dram_addr <= cb;
          phi0      <= !stall;
          lo        <= dram_q;
          if (wr) dram_d <= wd[7:4];
        end
        3'd4: cas_n <= (kind == K_REF);
        3'd5: begin
          cas_n <= 1'b1;
          we_n  <= 1'b1;
          if (kind == K_CPU && !wr) cpu_rdata <= {dram_q, lo};
          if (kind == K_VID) begin
            vid_data  <= {dram_q, lo};
            vid_valid <= 1'b1;
          end
        end
        3'd6: vid_valid <= 1'b0;
        default: begin
          ras_n <= 1'b1;
          phi0  <= 1'b0;
          par   <= ~par;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_clk_seq_chk.sv
`timescale 1ns/1ps
module dram_clk_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic phi0,
  input logic vid_valid
);
  assert_precharge_two_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n ##1 !ras_n));

  assert_ras_low_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> (!ras_n ##1 !ras_n ##1 !ras_n ##1 !ras_n ##1 !ras_n));

  assert_phi_high_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi0) |=> (phi0 ##1 phi0 ##1 phi0 ##1 !phi0));

  assert_phi_in_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phi0 |-> !ras_n);

  assert_cas_in_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  assert_cas_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> cas_n);

  assert_we_in_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ras_n);

  assert_vid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |=> !vid_valid);
endmodule

bind dram_clk_seq dram_clk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .phi0(phi0), .vid_valid(vid_valid)
);

// File: tb/tb_dram_clk_seq.sv
`timescale 1ns/1ps
module tb_dram_clk_seq;
  localparam int AW = 15;
  localparam int MW = 8;
  localparam int GAPN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cpu_addr = '0, vid_addr = '0;
  logic cpu_rw = 1'b1, cpu_ram = 1'b0, disp_active = 1'b0, hi_bw = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, vid_data;
  logic phi0, vid_valid, ras_n, cas_n, we_n;
  logic [MW-1:0] dram_addr;
  logic [3:0] dram_d, dram_q;
  logic [MW-1:0] b_row = '0;

  always #10 clk = ~clk;

  dram_clk_seq #(.AW(AW), .REF_GAP(GAPN)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_ram(cpu_ram), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .phi0(phi0), .vid_addr(vid_addr), .disp_active(disp_active),
    .hi_bw(hi_bw), .vid_data(vid_data), .vid_valid(vid_valid),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dram_d(dram_d), .dram_q(dram_q)
  );

  function automatic logic [3:0] hsh(input logic [7:0] r, input logic [7:0] c);
    hsh = r[3:0] ^ {r[6:4], r[7]} ^ c[3:0] ^ {c[5:4], c[7:6]} ^ 4'h5;
  endfunction

  always @(negedge clk) if (ras_n) b_row <= dram_addr;
  assign dram_q = hsh(b_row, dram_addr);

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: 0=refresh 1=video 2=cpu
  int k = 0, m_kind = 0, m_gap = 0, m_ref = 0;
  bit m_stall = 0, m_wr = 0;
  int m_row = 0, m_ca = 0, m_cb = 0, m_wd = 0, m_rdata = 0, m_vdata = 0;

  always @(posedge clk) if (rst_n) begin
    int p;
    p = k % 8;
    if (p == 0) begin
      bit vn;
      int a;
      vn = disp_active && (hi_bw || ((k / 8) % 2 == 0));
      if (vn) m_kind = 1;
      else if (m_gap == GAPN - 1) m_kind = 0;
      else if (cpu_ram) m_kind = 2;
      else m_kind = 0;
      m_stall = cpu_ram && (m_kind != 2);
      m_wr = (m_kind == 2) && !cpu_rw;
      m_wd = cpu_wdata;
      if (m_kind == 0) begin
        m_row = m_ref; m_ca = m_ref; m_cb = m_ref;
        m_ref = (m_ref + 1) % 256;
        m_gap = 0;
      end else begin
        a = (m_kind == 1) ? int'(vid_addr) : int'(cpu_addr);
        m_row = a / 128;
        m_ca = (a % 128) * 2;
        m_cb = m_ca + 1;
        if (m_gap < GAPN - 1) m_gap++;
      end
    end
    if (p == 5) begin
      if (m_kind == 2 && !m_wr) m_rdata = hsh(8'(m_row), 8'(m_cb)) * 16 + hsh(8'(m_row), 8'(m_ca));
      if (m_kind == 1) m_vdata = hsh(8'(m_row), 8'(m_cb)) * 16 + hsh(8'(m_row), 8'(m_ca));
    end
    k++;
  end

  always @(negedge clk) if (rst_n && !done) begin
    int p, ea;
    string t;
    p = k % 8;
    chk("R1", "ras_n", ras_n, (p <= 1) ? 1 : 0);
    chk(m_stall ? "R6" : "R2", "phi0", phi0, (p >= 4 && !m_stall) ? 1 : 0);
    ea = (p == 1) ? m_row : (p == 2 || p == 3) ? m_ca : m_cb;
    if (p == 1) t = (m_kind == 0) ? "R8" : (m_kind == 1) ? "R7" : "R5";
    else t = "R3";
    chk(t, "dram_addr", dram_addr, ea);
    chk("R4", "cas_n", cas_n, ((p == 3 || p == 5) && m_kind != 0) ? 0 : 1);
    chk("R9", "we_n", we_n, (p >= 2 && p <= 5 && m_wr) ? 0 : 1);
    if (!we_n) chk("R9", "dram_d", dram_d, (p <= 3) ? (m_wd % 16) : (m_wd / 16));
    chk("R10", "cpu_rdata", cpu_rdata, m_rdata);
    chk("R11", "vid_valid", vid_valid, (p == 6 && m_kind == 1) ? 1 : 0);
    chk("R11", "vid_data", vid_data, m_vdata);
  end

  task automatic slots(input int n);
    repeat (n * 8) @(negedge clk);
  endtask

  initial begin
    logic [31:0] lf;
    lf = 32'h1ACE_B00C;
    repeat (4) @(negedge clk);
    chk("R12", "reset ras_n", ras_n, 1);
    chk("R12", "reset cas_n", cas_n, 1);
    chk("R12", "reset we_n", we_n, 1);
    chk("R12", "reset phi0", phi0, 0);
    chk("R12", "reset vid_valid", vid_valid, 0);
    chk("R12", "reset dram_addr", dram_addr, 0);
    chk("R12", "reset cpu_rdata", cpu_rdata, 0);
    rst_n <= 1'b1;
    slots(20);
    cpu_ram = 1; cpu_rw = 1;
    for (int i = 0; i < 40; i++) begin
      cpu_addr = AW'(i * 389 + 7);
      slots(1);
    end
    cpu_rw = 0;
    for (int i = 0; i < 10; i++) begin
      cpu_addr = AW'(i * 1021);
      cpu_wdata = 8'(i * 37 + 3);
      slots(1);
    end
    cpu_rw = 1; disp_active = 1; hi_bw = 0;
    for (int i = 0; i < 20; i++) begin
      vid_addr = AW'(16'h3000 + i);
      cpu_addr = AW'(i * 55);
      slots(1);
    end
    hi_bw = 1;
    for (int i = 0; i < 24; i++) begin
      vid_addr = AW'(16'h5800 + i);
      slots(1);
    end
    disp_active = 0;
    slots(6);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cpu_ram = lf[0] | lf[3];
      cpu_rw = lf[1];
      cpu_addr = lf[19:5];
      cpu_wdata = lf[27:20];
      vid_addr = lf[30:16];
      if (lf[9:4] == 0) disp_active = ~disp_active;
      if (lf[15:10] == 0) hi_bw = ~hi_bw;
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule